// File: doc/BRIEF.md
# Flash Array Controller with Erase Sequencer

This block controls a small on-chip flash array that behaves like NOR flash, and it holds a small bank of user configuration words. Software reaches it through a 32-bit register port. Through that port it sets two enable bits, starts page erases, starts a full erase, clears the user bank, and reads and writes the user words. A separate word-write port stores data into the array. A write can only clear bits: the stored word becomes the old word ANDed with the new data. A combinational read port returns any array word.

Erases run on an internal sequencer that rewrites one array word per clock. While an erase runs, both the register port and the write port report not-ready, and any request on them waits. A one-cycle error pulse flags every rejected operation: a write while writes are disabled, an out-of-range address, an erase while erases are disabled, or a write to an unmapped offset. All accesses are whole 32-bit words.

Top module: `flash_ctl_top`

## Requirements
- R1: The configuration register is at word offset 1. Bit 0 enables writes and bit 1 enables erases. A write keeps only these two bits and clears the other 30, and the register reads back through `regRdata`.
- R2: Word offset 0 is a status word that always reads 1 (ready).
- R3: A write on the word-write port with byte address `wrAddr` targets word `wrAddr>>2`. If writes are enabled and that word lies inside the array, the word becomes old AND `wrData`. Otherwise nothing changes and an error pulse is raised.
- R4: A write to offset 2 or offset 3 takes a byte address, clears its in-page offset bits and, if erases are enabled, sets every word of that page to all-ones. Other pages are not touched.
- R5: A page erase issued while erases are disabled, or naming a page at or beyond the page count, changes nothing and raises an error pulse.
- R6: Writing the key value 1 to offset 4 while erases are enabled sets the whole array and every user word to all-ones. With erases disabled it changes nothing and raises an error pulse. Any other value is ignored and raises no error.
- R7: Writing the key value 1 to offset 5 sets every user word to all-ones whether or not erases are enabled. Any other value is ignored.
- R8: Reset sets every user word to all-ones and the configuration register to 0.
- R9: An erase busies the block for exactly one clock per erased word: PAGE_WORDS clocks for a page erase and PAGE_WORDS*PAGE_COUNT clocks for a full erase. During that time `regReady` and `wrReady` stay low, and a pending write waits and then takes effect.
- R10: `errPulse` is high for one clock, right after the rejected operation is accepted. A write to offset 0, or to any offset that is not mapped, is rejected.
- R11: User word k sits at register offset 8+k. It can be written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register request valid |
| regWrite | input | 1 | Request is a write |
| regAddr | input | REG_AW | Register word offset; also selects `regRdata` |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read of the offset on `regAddr` |
| regReady | output | 1 | Register port accepts a request |
| wrValid | input | 1 | Array word-write request |
| wrAddr | input | 32 | Array byte address |
| wrData | input | 32 | Data ANDed into the word |
| wrReady | output | 1 | Write port accepts a request |
| flashRdIdx | input | IDX_W | Array word index to read |
| flashRdData | output | 32 | Combinational array read |
| errPulse | output | 1 | One-cycle error flag |

## Verification
The AND-write is tried three ways. A second write to the same word separates a true AND from a plain overwrite. A write at a non-zero in-word byte offset confirms the word index. A write at the last word and one just past the array probe the bound. Page erases use an address with in-page offset bits set, a page just past the array, and a disabled enable bit; neighbouring pages are then read to show that only one page was cleared. The full erase and the user-bank clear are each run with the key, with a wrong value and with erases disabled, so that the enable dependence of one can be told from the enable independence of the other. Busy length is counted separately for a page erase and a full erase, with a write held pending throughout.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam int REG_STATUS    = 0;
  localparam int REG_CFG       = 1;
  localparam int REG_PAGE_A    = 2;
  localparam int REG_PAGE_B    = 3;
  localparam int REG_WIPE_ALL  = 4;
  localparam int REG_WIPE_USER = 5;
  localparam int USER_BASE     = 8;
  localparam int CFG_WEN       = 0;
  localparam int CFG_EEN       = 1;
  localparam logic [31:0] ERASE_KEY = 32'h1;

  typedef struct packed {
    logic andWrite;
    logic eraseWord;
    logic userWrite;
    logic userClear;
  } dpStrobe_t;
endpackage

// File: rtl/flash_ctl_ctrl.sv
module flash_ctl_ctrl
  import flash_ctl_pkg::*;
#(
  parameter int PAGE_WORDS = 8,
  parameter int PAGE_COUNT = 4,
  parameter int USER_WORDS = 4,
  localparam int TOTAL    = PAGE_WORDS * PAGE_COUNT,
  localparam int IDX_W    = $clog2(TOTAL),
  localparam int LOG_PW   = $clog2(PAGE_WORDS),
  localparam int PG_W     = $clog2(PAGE_COUNT),
  localparam int PAGE_SHIFT = LOG_PW + 2,
  localparam int REG_AW   = $clog2(USER_BASE + USER_WORDS),
  localparam int USER_IW  = $clog2(USER_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic              regReady,
  input  logic              wrValid,
  input  logic [31:0]       wrAddr,
  input  logic [31:0]       wrData,
  output logic              wrReady,
  output logic [1:0]        cfg,
  output dpStrobe_t         strobe,
  output logic [IDX_W-1:0]  wordIdx,
  output logic [31:0]       wordData,
  output logic [USER_IW-1:0] userIdx,
  output logic [31:0]       userData,
  output logic              errPulse
);
  logic busy;
  logic [IDX_W-1:0] seqIdx, seqEnd;
  logic regFire, wrFire, pageOk, wordOk;
  logic startPage, startAll, cfgWr, regErr, wrErr;
  logic [IDX_W-1:0] pageBase;

  assign regReady = !busy;
  assign wrReady  = !busy;
  assign regFire  = regValid && regWrite && !busy;
  assign wrFire   = wrValid && !busy;
  assign pageOk   = (regWdata >> PAGE_SHIFT) < 32'(PAGE_COUNT);
  assign wordOk   = (wrAddr >> 2) < 32'(TOTAL);
  assign pageBase = IDX_W'(regWdata[PAGE_SHIFT +: PG_W]) << LOG_PW;

  always_comb begin
    startPage = 1'b0;
    startAll  = 1'b0;
    cfgWr     = 1'b0;
    regErr    = 1'b0;
    strobe    = '0;
    if (regFire) begin
      if (int'(regAddr) == REG_CFG) begin
        cfgWr = 1'b1;
      end else if (int'(regAddr) == REG_PAGE_A || int'(regAddr) == REG_PAGE_B) begin
        if (cfg[CFG_EEN] && pageOk) startPage = 1'b1;
        else regErr = 1'b1;
      end else if (int'(regAddr) == REG_WIPE_ALL) begin
        if (regWdata == ERASE_KEY) begin
          if (cfg[CFG_EEN]) begin
            startAll = 1'b1;
            strobe.userClear = 1'b1;
          end else begin
            regErr = 1'b1;
          end
        end
      end else if (int'(regAddr) == REG_WIPE_USER) begin
        if (regWdata == ERASE_KEY) strobe.userClear = 1'b1;
      end else if (int'(regAddr) >= USER_BASE && int'(regAddr) < USER_BASE + USER_WORDS) begin
        strobe.userWrite = 1'b1;
      end else begin
        regErr = 1'b1;
      end
    end
    strobe.andWrite  = wrFire && cfg[CFG_WEN] && wordOk;
    strobe.eraseWord = busy;
  end

  assign wrErr    = wrFire && !(cfg[CFG_WEN] && wordOk);
  assign wordIdx  = busy ? seqIdx : wrAddr[2 +: IDX_W];
  assign wordData = wrData;
  assign userIdx  = USER_IW'(regAddr - REG_AW'(USER_BASE));
  assign userData = regWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      errPulse <= 1'b0;
      busy     <= 1'b0;
      seqIdx   <= '0;
      seqEnd   <= '0;
    end else begin
      if (cfgWr) cfg <= regWdata[1:0];
      errPulse <= regErr || wrErr;
      if (startPage) begin
        busy   <= 1'b1;
        seqIdx <= pageBase;
        seqEnd <= pageBase + IDX_W'(PAGE_WORDS - 1);
      end else if (startAll) begin
        busy   <= 1'b1;
        seqIdx <= '0;
        seqEnd <= IDX_W'(TOTAL - 1);
      end else if (busy) begin
        if (seqIdx == seqEnd) busy <= 1'b0;
        else seqIdx <= seqIdx + IDX_W'(1);
      end
    end
  end

  // R4: the sequencer only rewrites words while erases are enabled
  p_erase_een_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eraseWord |-> cfg[CFG_EEN]);
  // R9: configuration cannot change while an erase is running
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cfg));
  // R10: an error pulse always follows a request
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(regValid || wrValid));
endmodule

// File: rtl/flash_ctl_dp.sv
module flash_ctl_dp
  import flash_ctl_pkg::*;
#(
  parameter int PAGE_WORDS = 8,
  parameter int PAGE_COUNT = 4,
  parameter int USER_WORDS = 4,
  localparam int TOTAL   = PAGE_WORDS * PAGE_COUNT,
  localparam int IDX_W   = $clog2(TOTAL),
  localparam int REG_AW  = $clog2(USER_BASE + USER_WORDS),
  localparam int USER_IW = $clog2(USER_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [IDX_W-1:0]   wordIdx,
  input  logic [31:0]        wordData,
  input  logic [USER_IW-1:0] userIdx,
  input  logic [31:0]        userData,
  input  logic [1:0]         cfg,
  input  logic [REG_AW-1:0]  regAddr,
  output logic [31:0]        regRdata,
  input  logic [IDX_W-1:0]   flashRdIdx,
  output logic [31:0]        flashRdData
);
  logic [31:0] flashMem [TOTAL];
  logic [31:0] userMem  [USER_WORDS];

  always_ff @(posedge clk) begin
    if (strobe.andWrite)       flashMem[wordIdx] <= flashMem[wordIdx] & wordData;
    else if (strobe.eraseWord) flashMem[wordIdx] <= '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.userClear) begin
      for (int i = 0; i < USER_WORDS; i++) userMem[i] <= '1;
    end else if (strobe.userWrite) begin
      userMem[userIdx] <= userData;
    end
  end

  assign flashRdData = flashMem[flashRdIdx];

  always_comb begin
    regRdata = '0;
    if (int'(regAddr) == REG_STATUS) regRdata = 32'h1;
    else if (int'(regAddr) == REG_CFG) regRdata = {30'b0, cfg};
    else if (int'(regAddr) >= USER_BASE && int'(regAddr) < USER_BASE + USER_WORDS)
      regRdata = userMem[USER_IW'(regAddr - REG_AW'(USER_BASE))];
  end

  // R3: an accepted write leaves exactly old AND data
  p_and_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.andWrite |=> flashMem[$past(wordIdx)] == ($past(flashMem[wordIdx]) & $past(wordData)));
  // R4: every erase step leaves its word all-ones
  p_erase_ones_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eraseWord |=> flashMem[$past(wordIdx)] == 32'hFFFF_FFFF);
endmodule

// File: rtl/flash_ctl_top.sv
module flash_ctl_top
  import flash_ctl_pkg::*;
#(
  parameter int PAGE_WORDS = 8,
  parameter int PAGE_COUNT = 4,
  parameter int USER_WORDS = 4,
  localparam int TOTAL   = PAGE_WORDS * PAGE_COUNT,
  localparam int IDX_W   = $clog2(TOTAL),
  localparam int REG_AW  = $clog2(USER_BASE + USER_WORDS),
  localparam int USER_IW = $clog2(USER_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regReady,
  input  logic              wrValid,
  input  logic [31:0]       wrAddr,
  input  logic [31:0]       wrData,
  output logic              wrReady,
  input  logic [IDX_W-1:0]  flashRdIdx,
  output logic [31:0]       flashRdData,
  output logic              errPulse
);
  dpStrobe_t          strobe;
  logic [1:0]         cfg;
  logic [IDX_W-1:0]   wordIdx;
  logic [31:0]        wordData, userData;
  logic [USER_IW-1:0] userIdx;

  flash_ctl_ctrl #(.PAGE_WORDS(PAGE_WORDS), .PAGE_COUNT(PAGE_COUNT), .USER_WORDS(USER_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regReady(regReady), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrReady(wrReady), .cfg(cfg), .strobe(strobe), .wordIdx(wordIdx),
    .wordData(wordData), .userIdx(userIdx), .userData(userData), .errPulse(errPulse));

  flash_ctl_dp #(.PAGE_WORDS(PAGE_WORDS), .PAGE_COUNT(PAGE_COUNT), .USER_WORDS(USER_WORDS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx), .wordData(wordData),
    .userIdx(userIdx), .userData(userData), .cfg(cfg), .regAddr(regAddr),
    .regRdata(regRdata), .flashRdIdx(flashRdIdx), .flashRdData(flashRdData));
endmodule

// File: tb/flash_ctl_top_test.sv
`timescale 1ns/1ps
module flash_ctl_top_test;
  localparam int OP_REG = 0, OP_FW = 1, OP_CF = 2, OP_CR = 3;
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [31:0] addr;
    logic [31:0] data;
    logic        expErr;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd1, 32'h1, 32'hFFFF_FFFE, 1'b0},  // R1 mask: cfg=2
    '{2'd3, 4'd1, 32'h1, 32'h2, 1'b0},
    '{2'd0, 4'd6, 32'h4, 32'h1, 1'b0},          // R6 erase all
    '{2'd2, 4'd6, 32'd0, 32'hFFFF_FFFF, 1'b0},
    '{2'd2, 4'd6, 32'd31, 32'hFFFF_FFFF, 1'b0},
    '{2'd1, 4'd3, 32'h0, 32'h0, 1'b1},          // R3 write disabled
    '{2'd2, 4'd3, 32'd0, 32'hFFFF_FFFF, 1'b0},
    '{2'd0, 4'd1, 32'h1, 32'h3, 1'b0},
    '{2'd3, 4'd1, 32'h1, 32'h3, 1'b0},
    '{2'd1, 4'd3, 32'h4, 32'hF0F0_1234, 1'b0},
    '{2'd2, 4'd3, 32'd1, 32'hF0F0_1234, 1'b0},
    '{2'd1, 4'd3, 32'h4, 32'h0FFF_FF0F, 1'b0},  // R3 AND
    '{2'd2, 4'd3, 32'd1, 32'h00F0_1204, 1'b0},
    '{2'd1, 4'd3, 32'h23, 32'hA5A5_A5A5, 1'b0},
    '{2'd2, 4'd3, 32'd8, 32'hA5A5_A5A5, 1'b0},
    '{2'd1, 4'd3, 32'h7C, 32'h1, 1'b0},
    '{2'd2, 4'd3, 32'd31, 32'h1, 1'b0},
    '{2'd1, 4'd3, 32'h80, 32'h0, 1'b1},         // R3 out of range
    '{2'd0, 4'd11, 32'h8, 32'hCAFE_F00D, 1'b0}, // R11
    '{2'd3, 4'd11, 32'h8, 32'hCAFE_F00D, 1'b0},
    '{2'd0, 4'd11, 32'hB, 32'h5, 1'b0},
    '{2'd3, 4'd11, 32'hB, 32'h5, 1'b0},
    '{2'd0, 4'd4, 32'h3, 32'h2F, 1'b0},         // R4 page 1
    '{2'd2, 4'd4, 32'd8, 32'hFFFF_FFFF, 1'b0},
    '{2'd2, 4'd4, 32'd15, 32'hFFFF_FFFF, 1'b0},
    '{2'd2, 4'd4, 32'd1, 32'h00F0_1204, 1'b0},
    '{2'd2, 4'd4, 32'd31, 32'h1, 1'b0},
    '{2'd0, 4'd5, 32'h2, 32'h80, 1'b1},         // R5 beyond array
    '{2'd2, 4'd5, 32'd31, 32'h1, 1'b0},
    '{2'd0, 4'd1, 32'h1, 32'h1, 1'b0},
    '{2'd0, 4'd5, 32'h2, 32'h60, 1'b1},         // R5 disabled
    '{2'd2, 4'd5, 32'd31, 32'h1, 1'b0},
    '{2'd0, 4'd6, 32'h4, 32'h1, 1'b1},          // R6 disabled
    '{2'd2, 4'd6, 32'd1, 32'h00F0_1204, 1'b0},
    '{2'd3, 4'd6, 32'h8, 32'hCAFE_F00D, 1'b0},
    '{2'd0, 4'd7, 32'h5, 32'h2, 1'b0},          // R7 wrong key
    '{2'd3, 4'd7, 32'h8, 32'hCAFE_F00D, 1'b0},
    '{2'd0, 4'd7, 32'h5, 32'h1, 1'b0},          // R7 key, een off
    '{2'd3, 4'd7, 32'h8, 32'hFFFF_FFFF, 1'b0},
    '{2'd3, 4'd7, 32'hB, 32'hFFFF_FFFF, 1'b0},
    '{2'd0, 4'd11, 32'h8, 32'h12, 1'b0},
    '{2'd0, 4'd1, 32'h1, 32'h2, 1'b0},
    '{2'd0, 4'd6, 32'h4, 32'h0, 1'b0},          // R6 wrong key
    '{2'd2, 4'd6, 32'd1, 32'h00F0_1204, 1'b0},
    '{2'd3, 4'd6, 32'h8, 32'h12, 1'b0},
    '{2'd0, 4'd10, 32'h0, 32'h5, 1'b1},         // R10 status write
    '{2'd0, 4'd10, 32'h7, 32'h0, 1'b1},         // R10 unmapped
    '{2'd3, 4'd2, 32'h0, 32'h1, 1'b0},          // R2
    '{2'd0, 4'd6, 32'h4, 32'h1, 1'b0},
    '{2'd2, 4'd6, 32'd1, 32'hFFFF_FFFF, 1'b0},
    '{2'd2, 4'd6, 32'd31, 32'hFFFF_FFFF, 1'b0},
    '{2'd3, 4'd6, 32'h8, 32'hFFFF_FFFF, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic regValid = 1'b0, regWrite = 1'b0, wrValid = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0, wrAddr = '0, wrData = '0;
  logic [4:0] flashRdIdx = '0;
  logic [31:0] regRdata, flashRdData;
  logic regReady, wrReady, errPulse;
  int checks = 0, fails = 0, errSeen = 0;

  always #4 clk = ~clk;

  flash_ctl_top uut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regReady(regReady), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady), .flashRdIdx(flashRdIdx),
    .flashRdData(flashRdData), .errPulse(errPulse));

  always @(negedge clk) if (errPulse) errSeen++;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] a, input logic [31:0] d, input bit waitDone);
    while (!regReady) @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    if (waitDone) begin
      while (!regReady) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic flashWr(input logic [31:0] a, input logic [31:0] d);
    while (!wrReady) @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] readReg(input logic [3:0] a);
    regAddr = a;
    return regRdata;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int errBefore, cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regAddr = 4'h1; #1 check(8, regRdata, 32'h0, "cfg after reset");
    regAddr = 4'h8; #1 check(8, regRdata, 32'hFFFF_FFFF, "user0 after reset");
    regAddr = 4'hB; #1 check(8, regRdata, 32'hFFFF_FFFF, "user3 after reset");
    regAddr = 4'h0; #1 check(2, regRdata, 32'h1, "status");
    check(9, {31'b0, regReady & wrReady}, 32'h1, "ready after reset");

    for (int i = 0; i < NV; i++) begin
      errBefore = errSeen;
      case (int'(VEC[i].op))
        OP_REG: begin
          regWr(VEC[i].addr[3:0], VEC[i].data, 1'b1);
          check(int'(VEC[i].req), 32'(errSeen - errBefore), {31'b0, VEC[i].expErr}, $sformatf("entry %0d error count", i));
        end
        OP_FW: begin
          flashWr(VEC[i].addr, VEC[i].data);
          check(int'(VEC[i].req), 32'(errSeen - errBefore), {31'b0, VEC[i].expErr}, $sformatf("entry %0d error count", i));
        end
        OP_CF: begin
          flashRdIdx = VEC[i].addr[4:0]; #1;
          check(int'(VEC[i].req), flashRdData, VEC[i].data, $sformatf("entry %0d flash word", i));
        end
        default: begin
          regAddr = VEC[i].addr[3:0]; #1;
          check(int'(VEC[i].req), regRdata, VEC[i].data, $sformatf("entry %0d register", i));
        end
      endcase
      @(negedge clk);
    end

    // R9: page erase busy length, with a write pending throughout
    regWr(4'h1, 32'h3, 1'b1);
    regWr(4'h2, 32'h40, 1'b0);
    wrValid = 1'b1; wrAddr = 32'h40; wrData = 32'h0;
    cnt = 0;
    while (!regReady) begin
      if (wrReady) check(9, 32'h1, 32'h0, "wrReady during erase");
      cnt++;
      @(negedge clk);
    end
    check(9, 32'(cnt), 32'd8, "page erase busy cycles");
    @(negedge clk);
    wrValid = 1'b0;
    flashRdIdx = 5'd16; #1 check(9, flashRdData, 32'h0, "stalled write applied");
    flashRdIdx = 5'd17; #1 check(9, flashRdData, 32'hFFFF_FFFF, "neighbour erased");

    // R9: full erase busy length
    regWr(4'h4, 32'h1, 1'b0);
    cnt = 0;
    while (!regReady) begin cnt++; @(negedge clk); end
    check(9, 32'(cnt), 32'd32, "full erase busy cycles");
    flashRdIdx = 5'd16; #1 check(6, flashRdData, 32'hFFFF_FFFF, "full erase word 16");

    // R8: reset restores config and user bank
    regWr(4'h9, 32'h55, 1'b1);
    regAddr = 4'h9; #1 check(11, regRdata, 32'h55, "user1 write");
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regAddr = 4'h1; #1 check(8, regRdata, 32'h0, "cfg after second reset");
    regAddr = 4'h9; #1 check(8, regRdata, 32'hFFFF_FFFF, "user1 after second reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule